// File: doc/BRIEF.md
# Byte-wise CRC-16 register engine

This block is a bus-mapped peripheral that builds a 16-bit cyclic redundancy code over a stream of bytes. It uses the CCITT generator x^16 + x^12 + x^5 + 1. Software first writes a starting value into the 16-bit code register. It then writes the message one byte at a time into an 8-bit input register. Each accepted byte is folded into the running code. After two clock cycles the new code can be read back from the same 16-bit register.

Bits are consumed least-significant first against the reflected form of the generator, 0x8408, and no final inversion is applied. The code register can be written over a narrow bus as two independent byte lanes. While an update is in flight, a busy flag is set. A further byte write is stalled through a ready signal. A write to the code register cancels any pending update and loads the new seed.

Top module: `crc16_regs`

## Requirements
- R1: The code update is LSB-first with reflected polynomial 0x8408 and no final XOR: seed 0x0000 followed by byte 0x01 yields 0x1189.
- R2: A write to address 0 loads the code register per byte lane. `be_i[0]` writes bits 7:0 from `wdata_i[7:0]` and `be_i[1]` writes bits 15:8 from `wdata_i[15:8]`. A read of address 0 returns the code.
- R3: A write to address 1 with `be_i[0]` set starts an update with `wdata_i[7:0]`. The updated code is readable after the second rising edge that follows the write edge. While the block is idle and not written, the code does not change.
- R4: `busy_o` is high after the accepting edge and after the next edge, and low after the second edge. A read of address 2 returns `busy_o` in bit 0 and zeros elsewhere.
- R5: A write to address 1 while busy drives `ready_o` low, is not accepted, and leaves the update in progress unaffected. Holding the write until `ready_o` rises gets it accepted on the following edge.
- R6: A write to address 0 while busy aborts the update. On the next edge `busy_o` falls and the code register holds exactly the written seed, and it stays there.
- R7: Successive bytes accumulate: after each byte the code equals the reflected CRC of the seed and all bytes accepted so far.
- R8: A read of address 1 returns the last accepted input byte in bits 7:0 with bits 15:8 zero.
- R9: After reset `busy_o` is 0 and `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 code, 1 input byte, 2 status |
| wr_i | input | 1 | Write strobe |
| be_i | input | 2 | Byte-lane enables |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| busy_o | output | 1 | Update in progress |
| ready_o | output | 1 | Low when the current write must be held |

## Verification
A fixed list of seed/byte pairs comes first. It includes the all-zero seed with byte 0x01, the all-ones seed, and bytes with only the top bit or alternating bits set. This separates bit-order and polynomial mistakes from a swapped nibble order between the two processing cycles. Random seeds followed by random sequences of different lengths show whether the state carries correctly from one byte to the next, as opposed to being reloaded per byte. Directed cases then cover single-lane seed writes, a byte written during busy and held until ready, and a seed written one cycle into an update. These show whether lane enables, stall and abort priority are each honoured.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  typedef enum logic [1:0] {
    SEL_CODE = 2'd0,
    SEL_BYTE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // one reflected shift step of the code
  function automatic logic [15:0] refl_step(input logic [15:0] c, input logic d, input logic [15:0] poly);
    logic fb;
    fb = c[0] ^ d;
    return (c >> 1) ^ ({16{fb}} & poly);
  endfunction
endpackage

// File: rtl/crc16_decode.sv
module crc16_decode #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned LANES  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              busy_i,
  output logic [LANES-1:0]  load_lane_o,
  output logic              abort_o,
  output logic              start_o,
  output logic              ready_o,
  output crc16_pkg::reg_sel_e sel_o
);
  import crc16_pkg::*;

  logic hit_code, hit_byte, byte_req;

  always_comb begin
    case (addr_i[1:0])
      2'd0:    sel_o = SEL_CODE;
      2'd1:    sel_o = SEL_BYTE;
      2'd2:    sel_o = SEL_STAT;
      default: sel_o = SEL_NONE;
    endcase
    if (ADDR_W > 2 && (addr_i >> 2) != '0) sel_o = SEL_NONE;
  end

  assign hit_code = wr_i && (sel_o == SEL_CODE);
  assign hit_byte = wr_i && (sel_o == SEL_BYTE);
  assign byte_req = hit_byte && be_i[0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign load_lane_o[l] = hit_code && be_i[l];
  end

  assign abort_o = |load_lane_o;
  assign start_o = byte_req && !busy_i;
  assign ready_o = !(byte_req && busy_i);
endmodule

// File: rtl/crc16_seq.sv
module crc16_seq #(
  parameter int unsigned NCYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic step_o
);
  localparam int unsigned CNT_W = $clog2(NCYC + 1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (abort_i)       left_q <= '0;
    else if (start_i)       left_q <= CNT_W'(NCYC);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);
  assign step_o = busy_o && !abort_i;
endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath #(
  parameter int unsigned    CRC_W  = 16,
  parameter int unsigned    BYTE_W = 8,
  parameter int unsigned    STEPS  = 4,
  parameter logic [15:0]    POLY   = 16'h8408
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CRC_W/BYTE_W-1:0] load_lane_i,
  input  logic                    start_i,
  input  logic                    step_i,
  input  logic [CRC_W-1:0]        wdata_i,
  output logic [CRC_W-1:0]        code_o,
  output logic [BYTE_W-1:0]       byte_o
);
  localparam int unsigned LANES = CRC_W / BYTE_W;

  logic [CRC_W-1:0]  code_q;
  logic [BYTE_W-1:0] sh_q, in_q;

  logic [CRC_W-1:0]  c_w [STEPS+1];
  logic [BYTE_W-1:0] d_w [STEPS+1];

  assign c_w[0] = code_q;
  assign d_w[0] = sh_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign c_w[g+1] = crc16_pkg::refl_step(c_w[g], d_w[g][0], POLY);
    assign d_w[g+1] = d_w[g] >> 1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_code
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             code_q[l*BYTE_W +: BYTE_W] <= '0;
      else if (load_lane_i[l]) code_q[l*BYTE_W +: BYTE_W] <= wdata_i[l*BYTE_W +: BYTE_W];
      else if (step_i && load_lane_i == '0)
                               code_q[l*BYTE_W +: BYTE_W] <= c_w[STEPS][l*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      in_q <= '0;
    end else if (start_i) begin
      sh_q <= wdata_i[BYTE_W-1:0];
      in_q <= wdata_i[BYTE_W-1:0];
    end else if (step_i) begin
      sh_q <= d_w[STEPS];
    end
  end

  assign code_o = code_q;
  assign byte_o = in_q;
endmodule

// File: rtl/crc16_regs.sv
module crc16_regs #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned STEPS  = 4,
  parameter int unsigned ADDR_W = 2,
  parameter logic [15:0] POLY   = 16'h8408
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_i,
  input  logic [CRC_W/BYTE_W-1:0] be_i,
  input  logic [CRC_W-1:0]        wdata_i,
  output logic [CRC_W-1:0]        rdata_o,
  output logic                    busy_o,
  output logic                    ready_o
);
  import crc16_pkg::*;

  localparam int unsigned LANES = CRC_W / BYTE_W;
  localparam int unsigned NCYC  = BYTE_W / STEPS;

  logic [LANES-1:0]  load_lane;
  logic              abort, start, step, busy;
  logic [CRC_W-1:0]  code_w;
  logic [BYTE_W-1:0] byte_w;
  reg_sel_e          sel;

  crc16_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .addr_i, .wr_i, .be_i, .busy_i(busy),
    .load_lane_o(load_lane), .abort_o(abort), .start_o(start),
    .ready_o, .sel_o(sel)
  );

  crc16_seq #(.NCYC(NCYC)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .abort_i(abort),
    .busy_o(busy), .step_o(step)
  );

  crc16_datapath #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .STEPS(STEPS), .POLY(POLY)) u_dp (
    .clk_i, .rst_ni, .load_lane_i(load_lane), .start_i(start), .step_i(step),
    .wdata_i, .code_o(code_w), .byte_o(byte_w)
  );

  always_comb begin
    case (sel)
      SEL_CODE: rdata_o = code_w;
      SEL_BYTE: rdata_o = CRC_W'(byte_w);
      SEL_STAT: rdata_o = CRC_W'(busy);
      default:  rdata_o = '0;
    endcase
  end

  assign busy_o = busy;
endmodule

// File: rtl/crc16_regs_chk.sv
module crc16_regs_chk #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [LANES-1:0]  be_i,
  input logic [CRC_W-1:0]  wdata_i,
  input logic [CRC_W-1:0]  code_i,
  input logic              busy_o,
  input logic              ready_o
);
  logic byte_wr, code_wr_full;
  assign byte_wr      = wr_i && addr_i == ADDR_W'(1) && be_i[0];
  assign code_wr_full = wr_i && addr_i == ADDR_W'(0) && be_i == '1;

  a_r4_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_wr && !busy_o) |=> busy_o);

  a_r4_busy_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |=> !busy_o);

  a_r5_stall_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_wr && busy_o) |-> !ready_o);

  a_r6_abort_loads_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_wr_full |=> (!busy_o && code_i == $past(wdata_i)));

  a_r3_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !wr_i) |=> $stable(code_i));
endmodule

bind crc16_regs crc16_regs_chk #(.CRC_W(CRC_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .be_i, .wdata_i,
  .code_i(code_w), .busy_o, .ready_o
);

// File: tb/crc16_regs_tb.sv
module crc16_regs_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  addr = 0;
  logic        wr = 0;
  logic [1:0]  be = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        busy, ready;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  crc16_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .ready_o(ready)
  );

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  // write lands on the posedge between two negedges
  task automatic bus_wr(input logic [1:0] a, input logic [1:0] e, input logic [15:0] d);
    @(negedge clk);
    addr = a; be = e; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; be = 0;
  endtask

  task automatic push_byte(input logic [7:0] b, input logic [15:0] exp, input string req);
    logic [15:0] v;
    bus_wr(2'd1, 2'b01, {8'h00, b});
    #1 chk("R4 busy after accept", {15'd0, busy}, 16'd1);
    @(negedge clk);
    #1 chk("R4 busy after first step", {15'd0, busy}, 16'd1);
    @(negedge clk);
    #1 chk("R4 idle after second step", {15'd0, busy}, 16'd0);
    rd(2'd0, v);
    chk(req, v, exp);
  endtask

  localparam logic [23:0] VEC [8] = '{
    {16'h0000, 8'h01}, {16'hFFFF, 8'h00}, {16'hFFFF, 8'hFF}, {16'h0000, 8'h80},
    {16'h1D0F, 8'h55}, {16'hA5A5, 8'hAA}, {16'h8000, 8'h0F}, {16'h0001, 8'hF0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, model, seed;
    repeat (3) @(negedge clk);
    #1 chk("R9 reset busy", {15'd0, busy}, 16'd0);
    chk("R9 reset ready", {15'd0, ready}, 16'd1);
    rst_n = 1;

    // R1 known vector
    bus_wr(2'd0, 2'b11, 16'h0000);
    push_byte(8'h01, 16'h1189, "R1 seed 0000 byte 01");

    // R3 table walk
    for (int i = 0; i < 8; i++) begin
      bus_wr(2'd0, 2'b11, VEC[i][23:8]);
      rd(2'd0, v);
      chk("R2 seed readback", v, VEC[i][23:8]);
      push_byte(VEC[i][7:0], crc_ref(VEC[i][23:8], VEC[i][7:0]), "R3 table vector");
      rd(2'd1, v);
      chk("R8 input readback", v, {8'h00, VEC[i][7:0]});
    end

    // R3 idle stability
    repeat (3) @(negedge clk);
    rd(2'd0, v);
    chk("R3 idle code stable", v, crc_ref(VEC[7][23:8], VEC[7][7:0]));

    // R2 single lanes
    bus_wr(2'd0, 2'b11, 16'h1234);
    bus_wr(2'd0, 2'b01, 16'hFFAB);
    rd(2'd0, v);
    chk("R2 low lane only", v, 16'h12AB);
    bus_wr(2'd0, 2'b10, 16'hCDFF);
    rd(2'd0, v);
    chk("R2 high lane only", v, 16'hCDAB);

    // R4 status register
    bus_wr(2'd1, 2'b01, 16'h003C);
    rd(2'd2, v);
    chk("R4 status busy", v, 16'h0001);
    @(negedge clk); @(negedge clk);
    rd(2'd2, v);
    chk("R4 status idle", v, 16'h0000);

    // R5 stall while busy
    bus_wr(2'd0, 2'b11, 16'hBEEF);
    bus_wr(2'd1, 2'b01, 16'h0042);
    addr = 2'd1; be = 2'b01; wdata = 16'h0099; wr = 1;
    #1 chk("R5 ready low while busy", {15'd0, ready}, 16'd0);
    @(negedge clk);
    #1 chk("R5 still stalled", {15'd0, ready}, 16'd0);
    @(negedge clk);
    #1 chk("R5 ready after update", {15'd0, ready}, 16'd1);
    wr = 0; addr = 2'd0;
    #1 chk("R5 first byte unaffected", rdata, crc_ref(16'hBEEF, 8'h42));
    wr = 1; addr = 2'd1;
    @(negedge clk);
    wr = 0; be = 0;
    @(negedge clk); @(negedge clk);
    rd(2'd0, v);
    chk("R5 held byte accepted", v, crc_ref(crc_ref(16'hBEEF, 8'h42), 8'h99));

    // R6 abort
    bus_wr(2'd1, 2'b01, 16'h00E7);
    bus_wr(2'd0, 2'b11, 16'h5A5A);
    #1 chk("R6 busy cleared", {15'd0, busy}, 16'd0);
    rd(2'd0, v);
    chk("R6 seed loaded", v, 16'h5A5A);
    @(negedge clk); @(negedge clk);
    rd(2'd0, v);
    chk("R6 seed kept", v, 16'h5A5A);

    // R7 random sequences
    for (int s = 0; s < 6; s++) begin
      seed = 16'($urandom);
      model = seed;
      bus_wr(2'd0, 2'b11, seed);
      for (int n = 0; n < 1 + 3 * s; n++) begin
        logic [7:0] b;
        b = 8'($urandom);
        model = crc_ref(model, b);
        push_byte(b, model, "R7 accumulated sequence");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule